// File: doc/BRIEF.md
# Memory-Mapped Ready/Valid Channel Bridge

This block sits between a simple processor load/store port and two streaming channels that use a valid/ready handshake. One channel carries words out and the other carries words in. Software sees three byte-addressed registers. The status register reports whether the outgoing channel can take a word and whether an incoming word is waiting. The data register sends a word when written and returns the incoming word when read. The peer register sets the endpoint that outgoing words are tagged with when written, and returns the endpoint that sent the waiting incoming word when read.

A processor request is one cycle wide. The block answers with a one-cycle acknowledge. A send that the outgoing channel cannot yet accept stalls the acknowledge until the handshake completes. While that send is pending, new requests are ignored, so the processor must wait for the acknowledge. Because reading the data register consumes the incoming word, software reads the sender endpoint first and then the data.

Top module: `sp_bridge`

## Requirements
- R1: A read at byte offset 0 returns status: bit 0 is 1 when the outgoing channel is ready (tx_ready high in the request cycle) and bit 1 equals rx_valid in the request cycle. All other bits read 0.
- R2: Every request accepted while no send is pending, other than a data write, gives cpu_ack high for exactly the one cycle after the request cycle. Read data is presented on cpu_rdata in that same cycle.
- R3: A write at offset 4 raises tx_valid in the next cycle, carrying tx_data equal to the write data and tx_dest equal to the peer register. These values stay stable until tx_ready is seen. cpu_ack is high exactly in the cycle the handshake completes (tx_valid and tx_ready both high), and tx_valid is low afterwards.
- R4: A write at offset 8 loads the low ID_W bits of the write data into the peer register. Every later send carries this value on tx_dest.
- R5: A read at offset 4 while rx_valid is high returns rx_data. It also drives rx_ready high in the request cycle only, which consumes the word.
- R6: A read at offset 4 while rx_valid is low returns 0 and leaves rx_ready low.
- R7: A read at offset 8 returns rx_src, zero-extended, when rx_valid is high, and 0 otherwise. It never drives rx_ready.
- R8: Addresses are decoded as byte addresses with no shift, so offsets such as 1, 2, 3, 5 and 12 are unmapped. Reads from them return 0. Writes to them, and writes to offset 0, change nothing and are acknowledged as in R2.
- R9: After reset the peer register is 0, and tx_valid, rx_ready and cpu_ack are low.
- R10: Requests presented while a send is pending are ignored. They give no acknowledge and change neither the peer register nor the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle (a write wins if both are high) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid in the acknowledge cycle |
| cpu_ack | output | 1 | Request done |
| tx_data | output | DATA_W | Outgoing word |
| tx_dest | output | ID_W | Destination endpoint of the outgoing word |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Outgoing channel accepts |
| rx_data | input | DATA_W | Incoming word |
| rx_src | input | ID_W | Sender endpoint of the incoming word |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Incoming word consumed |

## Verification
Reads and non-data writes are acknowledged one cycle after the request, with data registered into that cycle. The bench therefore drives a request at a falling edge and samples cpu_ack and cpu_rdata at the next falling edge. rx_ready is combinational in the request cycle, so it is sampled one time unit after the request is driven, before the capturing edge. A stalled send is sampled on every falling edge while tx_ready is held low, to check that ack stays low and the word stays stable. It is sampled again just after tx_ready rises, where ack must already be high, and one cycle later, where tx_valid must be low. Random operations are compared against a bench model of the peer register and the status and read-data rules.

// File: rtl/sp_bridge_pkg.sv
package sp_bridge_pkg;

   // register selection decoded from the byte address
   typedef enum logic [1:0] {
      SEL_STAT = 2'd0,
      SEL_DATA = 2'd1,
      SEL_PEER = 2'd2,
      SEL_NONE = 2'd3
   } sp_sel_e;

   localparam int unsigned OFS_STAT = 0;
   localparam int unsigned OFS_DATA = 4;
   localparam int unsigned OFS_PEER = 8;

   localparam int unsigned STAT_TX_BIT = 0;
   localparam int unsigned STAT_RX_BIT = 1;

endpackage

// File: rtl/sp_decode.sv
module sp_decode
   import sp_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output sp_sel_e           sel
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_PEER = ADDR_W'(OFS_PEER);

   // full byte-address compare: no word shift, low bits must be zero
   always_comb begin
      if (addr == A_STAT)      sel = SEL_STAT;
      else if (addr == A_DATA) sel = SEL_DATA;
      else if (addr == A_PEER) sel = SEL_PEER;
      else                     sel = SEL_NONE;
   end

endmodule

// File: rtl/sp_tx_stage.sv
module sp_tx_stage #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [ID_W-1:0]   load_dest,
   output logic [DATA_W-1:0] tx_data,
   output logic [ID_W-1:0]   tx_dest,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              done
);

   logic [DATA_W-1:0] word_q;
   logic [ID_W-1:0]   dest_q;
   logic              valid_q;

   assign done     = valid_q & tx_ready;
   assign tx_data  = word_q;
   assign tx_dest  = dest_q;
   assign tx_valid = valid_q;

   // word and destination are captured in the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         word_q  <= '0;
         dest_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         word_q  <= load_data;
         dest_q  <= load_dest;
      end else if (done) begin
         valid_q <= 1'b0;
      end
   end

   // pending word must not move until it is taken
   assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_dest)));

   // a new word is never loaded over a pending one
   assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !tx_valid);

endmodule

// File: rtl/sp_rx_read.sv
module sp_rx_read
   import sp_bridge_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sp_sel_e           sel,
   input  logic              rd_go,
   input  logic              tx_can,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [ID_W-1:0]   rx_src,
   output logic              rx_ready,
   output logic [DATA_W-1:0] rd_word
);

   localparam int unsigned PAD_W = DATA_W - ID_W;

   logic [DATA_W-1:0] src_ext;
   logic [DATA_W-1:0] stat_word;

   // widen the sender identifier to the data width
   generate
      if (PAD_W == 0) begin : g_src_full
         assign src_ext = rx_src;
      end else begin : g_src_pad
         assign src_ext = {{PAD_W{1'b0}}, rx_src};
      end
   endgenerate

   always_comb begin
      stat_word              = '0;
      stat_word[STAT_TX_BIT] = tx_can;
      stat_word[STAT_RX_BIT] = rx_valid;
   end

   // only a data read consumes, and only when a word is there
   assign rx_ready = rd_go & (sel == SEL_DATA) & rx_valid;

   always_comb begin
      unique case (sel)
         SEL_STAT: rd_word = stat_word;
         SEL_DATA: rd_word = rx_valid ? rx_data : '0;
         SEL_PEER: rd_word = rx_valid ? src_ext : '0;
         default:  rd_word = '0;
      endcase
   end

   assert_take_only_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> rx_valid);

   assert_peer_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_PEER) |-> !rx_ready);

endmodule

// File: rtl/sp_bridge.sv
module sp_bridge
   import sp_bridge_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] tx_data,
   output logic [ID_W-1:0]   tx_dest,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [ID_W-1:0]   rx_src,
   input  logic              rx_valid,
   output logic              rx_ready
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("sp_bridge: ADDR_W must reach offset 8");
      end
      if (ID_W < 1 || ID_W > DATA_W) begin : g_bad_id
         $error("sp_bridge: ID_W must be 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("sp_bridge: DATA_W must hold both status bits");
      end
   endgenerate

   sp_sel_e           sel;
   logic              idle;
   logic              wr_go;
   logic              rd_go;
   logic              tx_load;
   logic              tx_done;
   logic              tx_can;
   logic [ID_W-1:0]   peer_q;
   logic              ack_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_word;

   sp_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (cpu_addr),
      .sel  (sel)
   );

   assign idle    = ~tx_valid;
   assign wr_go   = idle & cpu_wr;
   assign rd_go   = idle & cpu_rd & ~cpu_wr;
   assign tx_load = wr_go & (sel == SEL_DATA);
   assign tx_can  = tx_ready & idle;

   sp_tx_stage #(.DATA_W(DATA_W), .ID_W(ID_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tx_load),
      .load_data (cpu_wdata),
      .load_dest (peer_q),
      .tx_data   (tx_data),
      .tx_dest   (tx_dest),
      .tx_valid  (tx_valid),
      .tx_ready  (tx_ready),
      .done      (tx_done)
   );

   sp_rx_read #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .rd_go    (rd_go),
      .tx_can   (tx_can),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_src   (rx_src),
      .rx_ready (rx_ready),
      .rd_word  (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peer_q  <= '0;
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (wr_go && sel == SEL_PEER) peer_q <= cpu_wdata[ID_W-1:0];
         ack_q   <= rd_go | (wr_go & (sel != SEL_DATA));
         rdata_q <= rd_go ? rd_word : '0;
      end
   end

   // a send acknowledges in the cycle its handshake completes
   assign cpu_ack   = ack_q | tx_done;
   assign cpu_rdata = rdata_q;

   assert_ack_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go || (wr_go && sel != SEL_DATA)) |=> cpu_ack);

   assert_stall_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |-> !cpu_ack);

   assert_busy_peer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> $stable(peer_q));

   assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && !tx_valid && !$past(cpu_wr || cpu_rd)) |-> 1'b0);

endmodule

// File: tb/sp_bridge_test.sv
module sp_bridge_test;

   localparam int CLK_P = 10;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_ack;
   logic [DW-1:0] tx_data;
   logic [IW-1:0] tx_dest;
   logic          tx_valid;
   logic          tx_ready = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [IW-1:0] rx_src = '0;
   logic          rx_valid = 1'b0;
   logic          rx_ready;

   int total = 0;
   int bad = 0;
   logic [IW-1:0] peer_m = '0;

   always #(CLK_P/2) clk = ~clk;

   sp_bridge #(.DATA_W(DW), .ADDR_W(AW), .ID_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ack(cpu_ack), .tx_data(tx_data), .tx_dest(tx_dest),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
      .rx_src(rx_src), .rx_valid(rx_valid), .rx_ready(rx_ready)
   );

   function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a, logic txr,
                                              logic rxv, logic [DW-1:0] rxd,
                                              logic [IW-1:0] rxs);
      if (a == 8'd0) return {30'd0, rxv, txr};
      if (a == 8'd4) return rxv ? rxd : '0;
      if (a == 8'd8) return rxv ? {28'd0, rxs} : '0;
      return '0;
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one-cycle request; samples rx_ready in the request cycle, ack/rdata one cycle later
   task automatic issue(bit wr, bit rd, logic [AW-1:0] a, logic [DW-1:0] wd,
                        logic txr, logic rxv, logic [DW-1:0] rxd, logic [IW-1:0] rxs,
                        string req);
      logic take;
      @(negedge clk);
      cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = wd;
      tx_ready = txr; rx_valid = rxv; rx_data = rxd; rx_src = rxs;
      #1 take = rx_ready;
      check({req, " rx_ready"}, {31'd0, take},
            {31'd0, (rd && !wr && a == 8'd4 && rxv)});
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b0;
      #1;
      check({req, " ack"}, {31'd0, cpu_ack}, 32'd1);
      if (rd && !wr) check({req, " rdata"}, cpu_rdata, exp_read(a, txr, rxv, rxd, rxs));
      if (wr && a == 8'd8) peer_m = wd[IW-1:0];
   endtask

   // send a word; tx_ready held low for 'stall' cycles, with a stray request while waiting
   task automatic send(logic [DW-1:0] w, int stall, string req);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = 8'd4; cpu_wdata = w; tx_ready = (stall == 0);
      rx_valid = 1'b0;
      @(negedge clk);
      cpu_wr = 1'b0;
      #1;
      check({req, " tx_valid"}, {31'd0, tx_valid}, 32'd1);
      check({req, " tx_data"}, tx_data, w);
      check({req, " tx_dest"}, {28'd0, tx_dest}, {28'd0, peer_m});
      for (int k = 0; k < stall; k++) begin
         check({req, " stalled ack R3"}, {31'd0, cpu_ack}, 32'd0);
         // R10: a peer write while busy must be dropped
         cpu_wr = (k == 0); cpu_addr = 8'd8; cpu_wdata = ~{28'd0, peer_m};
         @(negedge clk);
         cpu_wr = 1'b0;
         #1;
         check({req, " held data R3"}, tx_data, w);
         check({req, " held dest R10"}, {28'd0, tx_dest}, {28'd0, peer_m});
         check({req, " no ack busy R10"}, {31'd0, cpu_ack}, 32'd0);
      end
      if (stall != 0) begin
         tx_ready = 1'b1;
         #1;
      end
      check({req, " handshake ack R3"}, {31'd0, cpu_ack}, 32'd1);
      @(negedge clk);
      tx_ready = 1'b0;
      #1;
      check({req, " tx_valid low R3"}, {31'd0, tx_valid}, 32'd0);
      check({req, " ack once R2"}, {31'd0, cpu_ack}, 32'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2468));
      repeat (3) @(negedge clk);
      rx_valid = 1'b1;
      rst_n = 1'b1;
      #1;
      // R9 reset state
      check("R9 tx_valid", {31'd0, tx_valid}, 32'd0);
      check("R9 ack", {31'd0, cpu_ack}, 32'd0);
      check("R9 rx_ready", {31'd0, rx_ready}, 32'd0);
      send(32'hCAFE_0001, 0, "R9 dest zero / R3");

      // directed cases
      issue(0, 1, 8'd0, 0, 1, 1, 0, 0, "R1 status both");
      issue(0, 1, 8'd0, 0, 0, 0, 0, 0, "R1 status none");
      issue(1, 0, 8'd8, 32'hFFFF_FFF5, 0, 0, 0, 0, "R4 peer write");
      send(32'h1234_5678, 3, "R4 R3 stalled send");
      issue(0, 1, 8'd8, 0, 0, 1, 32'h55, 4'hA, "R7 peer read");
      issue(0, 1, 8'd4, 0, 0, 1, 32'hDEAD_BEEF, 4'hA, "R5 data read");
      issue(0, 1, 8'd4, 0, 0, 0, 32'hDEAD_BEEF, 4'hA, "R6 empty read");
      issue(0, 1, 8'd8, 0, 0, 0, 0, 4'h3, "R7 empty peer");
      issue(0, 1, 8'd1, 0, 1, 1, 32'h77, 4'h1, "R8 unmapped 1");
      issue(0, 1, 8'd12, 0, 1, 1, 32'h77, 4'h1, "R8 unmapped 12");
      issue(1, 0, 8'd2, 32'h3, 0, 0, 0, 0, "R8 write unmapped");
      issue(1, 0, 8'd0, 32'h7, 0, 0, 0, 0, "R8 write status");
      issue(1, 0, 8'd9, 32'h9, 0, 0, 0, 0, "R8 write off-by-one");
      send(32'h0BAD_F00D, 1, "R8 dest unchanged");

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [DW-1:0] d;
         logic [AW-1:0] ua;
         op = $urandom % 7;
         d = $urandom;
         ua = 8'(($urandom % 4) + 1);
         if (ua == 8'd4) ua = 8'd13;
         case (op)
            0: issue(0, 1, 8'd0, 0, 1'($urandom), 1'($urandom), d, 4'($urandom), "R1 rand status");
            1: issue(0, 1, 8'd4, 0, 1'($urandom), 1'($urandom), d, 4'($urandom), "R5 R6 rand data");
            2: issue(0, 1, 8'd8, 0, 1'($urandom), 1'($urandom), d, 4'($urandom), "R7 rand peer");
            3: issue(1, 0, 8'd8, d, 0, 0, 0, 0, "R4 rand peer write");
            4: send(d, int'($urandom % 4), "R3 rand send");
            5: issue(0, 1, ua, 0, 1, 1, d, 4'($urandom), "R8 rand unmapped read");
            default: issue(1, 0, ua, d, 0, 0, 0, 0, "R8 rand unmapped write");
         endcase
      end
      send(32'hFEED_0000, 0, "R4 final dest");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule